// File: doc/BRIEF.md
# Processor Feature-Report Masking Unit

This unit sits on the return path of a processor identification query. It receives the function number and the four native 32-bit result words (A, B, C, D) of each query. For the basic feature function (01H) and the extended feature function (80000001H), it clears chosen feature bits in words C and D before handing the words back. Clearing a bit hides a feature from software, which lets a pool of unlike processors all report the same feature set. The unit can only clear bits. It can never make an absent feature appear.

Each mask is a 64-bit register. The low half gates word C and the high half gates word D. The registers are written and read through a simple model-specific-register bus: address, 64-bit write data, a write strobe, a read strobe, registered read data and an error flag.

The parameter `PROC_SIG` is a 32-bit processor signature with the following fields:
- extended family in bits 27:20
- extended model in bits 19:16
- family in bits 11:8
- model in bits 7:4

The signature decides how many mask registers exist and at which addresses they appear. Where a mask is absent, its words pass through unchanged.

The result path is one registered stage. It is controlled by a two-state machine:
- `ST_IDLE`: no result is being presented.
- `ST_DELIVER`: a result is presented, with `rsp_valid` high.

The machine has two transitions:
- It goes to `ST_DELIVER` on any cycle where `qry_valid` is high, from either state.
- It returns to `ST_IDLE` on any cycle where `qry_valid` is low.

Top module: `featmask_unit`

## Requirements
- R1: After reset, every implemented mask register reads back as all ones (FFFFFFFF_FFFFFFFFH). A query made right after reset returns its native words unchanged.
- R2: For function 00000001H, the returned C word equals native C AND basic-mask bits 31:0. The returned D word equals native D AND basic-mask bits 63:32.
- R3: On a dual-mask model, function 80000001H returns C AND extended-mask bits 31:0 and D AND extended-mask bits 63:32.
- R4: A dual-mask model has the following layout:
  - Its signature has family 6H and extended family 00H, together with extended model 1H and model AH, EH or FH, or extended model 2H and model 5H, CH, EH or FH.
  - The basic mask is at address 130H and the extended mask at 131H.

  A single-mask model has the following layout:
  - Its signature has family 6H and extended family 00H, with extended model 1H and model 7H or DH.
  - Its basic mask is at 478H.
  - It has no extended mask, so function 80000001H passes unmasked and address 131H is unimplemented.
- R5: Words A and B of every function are returned unchanged. All four words of any function other than 01H and 80000001H are returned unchanged.
- R6: Every returned C and D bit that is 1 is also 1 in the native word.
- R7: If the signature does not have family 6H and extended family 00H, or matches no model listed in R4, no address is implemented and every query passes through unchanged.
- R8: A read or write to an address that is not implemented raises `cfg_err` for exactly one cycle, one clock after the strobe. Such an access changes no mask.
- R9: A read of an implemented mask returns, one clock after `cfg_rd`, the full 64-bit value last written, with `cfg_err` low.
- R10: `rsp_valid` rises one clock after `qry_valid` and carries that query's result. A mask write issued in the same cycle as a query takes effect from the next query on.
- R11: Clearing bit 23 of the basic mask makes function 01H report 0 in C bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Mask register address |
| cfg_wdata | input | 64 | Mask write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 64 | Registered read data |
| cfg_err | output | 1 | One-cycle flag for an unimplemented address |
| qry_valid | input | 1 | Query present |
| qry_func | input | 32 | Function number of the query |
| qry_a | input | 32 | Native word A |
| qry_b | input | 32 | Native word B |
| qry_c | input | 32 | Native word C |
| qry_d | input | 32 | Native word D |
| rsp_valid | output | 1 | Result valid, one clock after `qry_valid` |
| rsp_a | output | 32 | Returned word A |
| rsp_b | output | 32 | Returned word B |
| rsp_c | output | 32 | Returned word C, masked |
| rsp_d | output | 32 | Returned word D, masked |

## Verification
The bench runs three builds side by side from the same stimulus: a dual-mask signature, a single-mask signature and an unsupported signature. A difference between them can only come from the decoded signature.

The vector table pairs native words with mask values. The all-ones and all-zero patterns separate pass-through from masking. Alternating nibble patterns show that the C word is gated by the low half of a mask and the D word by the high half, never the other way round. A lone bit 23 shows single-bit control.

Queries to an unmasked function made while the masks hold zeros show that no other function is touched. A write and a query issued in the same cycle separate old-mask from new-mask timing.

// File: rtl/featmask_pkg.sv
package featmask_pkg;

    localparam int          NUM_MASK = 2;
    localparam int          MASK_W   = 64;
    localparam logic [31:0] FN_BASIC = 32'h0000_0001;
    localparam logic [31:0] FN_EXT   = 32'h8000_0001;

    typedef enum logic [1:0] {
        TIER_NONE,
        TIER_SINGLE,
        TIER_DUAL
    } mask_tier_e;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d;
    } quad_t;

    function automatic mask_tier_e decode_tier(input logic [31:0] sig);
        logic [7:0] xfam;
        logic [3:0] fam;
        logic [3:0] xmod;
        logic [3:0] mdl;
        mask_tier_e t;
        xfam = sig[27:20];
        fam  = sig[11:8];
        xmod = sig[19:16];
        mdl  = sig[7:4];
        t    = TIER_NONE;
        if (xfam == 8'h00 && fam == 4'h6) begin
            if (xmod == 4'h1 && (mdl == 4'h7 || mdl == 4'hD)) begin
                t = TIER_SINGLE;
            end else if (xmod == 4'h1 && (mdl == 4'hA || mdl == 4'hE || mdl == 4'hF)) begin
                t = TIER_DUAL;
            end else if (xmod == 4'h2 && (mdl == 4'h5 || mdl == 4'hC || mdl == 4'hE || mdl == 4'hF)) begin
                t = TIER_DUAL;
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/featmask_regs.sv
module featmask_regs #(
    parameter int                      ADDR_W = 32,
    parameter int                      MASK_W = 64,
    parameter int                      NUM    = 2,
    parameter logic [NUM-1:0]          IMPL   = '1,
    parameter logic [NUM*ADDR_W-1:0]   ADDRS  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [MASK_W-1:0]     cfg_wdata,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    output logic [MASK_W-1:0]     cfg_rdata,
    output logic                  cfg_err,
    output logic [NUM*MASK_W-1:0] masks
);

    logic [NUM-1:0]    hit;
    logic [MASK_W-1:0] sel;
    logic              any_hit;

    for (genvar i = 0; i < NUM; i++) begin : g_mask
        if (IMPL[i]) begin : g_impl
            logic [MASK_W-1:0] mask_q;
            assign hit[i] = (cfg_addr == ADDRS[i*ADDR_W +: ADDR_W]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q <= '1;
                end else if (cfg_wr && hit[i]) begin
                    mask_q <= cfg_wdata;
                end
            end
            assign masks[i*MASK_W +: MASK_W] = mask_q;
        end else begin : g_absent
            assign hit[i]                    = 1'b0;
            assign masks[i*MASK_W +: MASK_W] = '1;
        end
    end

    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int k = 0; k < NUM; k++) begin
            if (hit[k]) begin
                sel     = masks[k*MASK_W +: MASK_W];
                any_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_err <= (cfg_wr || cfg_rd) && !any_hit;
            if (cfg_rd) begin
                cfg_rdata <= sel;
            end
        end
    end

endmodule

// File: rtl/featmask_stage.sv
module featmask_stage
    import featmask_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qry_valid,
    input  logic [31:0]       qry_func,
    input  quad_t             qry_word,
    input  logic [MASK_W-1:0] mask_basic,
    input  logic [MASK_W-1:0] mask_ext,
    output logic              rsp_valid,
    output quad_t             rsp_word
);

    localparam int HALF = MASK_W / 2;

    typedef enum logic {
        ST_IDLE,
        ST_DELIVER
    } stage_state_e;

    stage_state_e state_q, state_d;
    quad_t        masked;

    always_comb begin
        masked = qry_word;
        if (qry_func == FN_BASIC) begin
            masked.c = qry_word.c & mask_basic[HALF-1:0];
            masked.d = qry_word.d & mask_basic[MASK_W-1:HALF];
        end else if (qry_func == FN_EXT) begin
            masked.c = qry_word.c & mask_ext[HALF-1:0];
            masked.d = qry_word.d & mask_ext[MASK_W-1:HALF];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = qry_valid ? ST_DELIVER : ST_IDLE;
            ST_DELIVER: state_d = qry_valid ? ST_DELIVER : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_word <= '0;
        end else if (qry_valid) begin
            rsp_word <= masked;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_DELIVER);
    end

endmodule

// File: rtl/featmask_unit.sv
module featmask_unit
    import featmask_pkg::*;
#(
    parameter logic [31:0] PROC_SIG = 32'h0002_06C2,
    parameter int          ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    output logic [63:0]       cfg_rdata,
    output logic              cfg_err,
    input  logic              qry_valid,
    input  logic [31:0]       qry_func,
    input  logic [31:0]       qry_a,
    input  logic [31:0]       qry_b,
    input  logic [31:0]       qry_c,
    input  logic [31:0]       qry_d,
    output logic              rsp_valid,
    output logic [31:0]       rsp_a,
    output logic [31:0]       rsp_b,
    output logic [31:0]       rsp_c,
    output logic [31:0]       rsp_d
);

    localparam mask_tier_e          TIER   = decode_tier(PROC_SIG);
    localparam logic [NUM_MASK-1:0] IMPL   = (TIER == TIER_DUAL)   ? 2'b11 :
                                             (TIER == TIER_SINGLE) ? 2'b01 : 2'b00;
    localparam logic [ADDR_W-1:0]   ADDR_B = ADDR_W'(32'h0000_0478 >> ((TIER == TIER_DUAL) ? 32 : 0))
                                             | ((TIER == TIER_DUAL) ? ADDR_W'(32'h130) : '0);
    localparam logic [ADDR_W-1:0]   ADDR_X = ADDR_W'(32'h0000_0131);

    logic [NUM_MASK*MASK_W-1:0] masks;
    quad_t                      q_word, r_word;

    featmask_regs #(
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W),
        .NUM    (NUM_MASK),
        .IMPL   (IMPL),
        .ADDRS  ({ADDR_X, ADDR_B})
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .masks     (masks)
    );

    assign q_word = '{a: qry_a, b: qry_b, c: qry_c, d: qry_d};

    featmask_stage #(
        .MASK_W (MASK_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .qry_valid  (qry_valid),
        .qry_func   (qry_func),
        .qry_word   (q_word),
        .mask_basic (masks[MASK_W-1:0]),
        .mask_ext   (masks[2*MASK_W-1:MASK_W]),
        .rsp_valid  (rsp_valid),
        .rsp_word   (r_word)
    );

    assign rsp_a = r_word.a;
    assign rsp_b = r_word.b;
    assign rsp_c = r_word.c;
    assign rsp_d = r_word.d;

endmodule

// File: rtl/featmask_chk.sv
module featmask_chk
    import featmask_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic        cfg_rd,
    input logic        cfg_err,
    input logic        qry_valid,
    input logic [31:0] qry_func,
    input logic [31:0] qry_a,
    input logic [31:0] qry_b,
    input logic [31:0] qry_c,
    input logic [31:0] qry_d,
    input logic        rsp_valid,
    input logic [31:0] rsp_a,
    input logic [31:0] rsp_b,
    input logic [31:0] rsp_c,
    input logic [31:0] rsp_d
);

    // R10
    rsp_follows_qry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> rsp_valid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_valid |=> !rsp_valid);

    // R6
    only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> ((rsp_c & ~$past(qry_c)) == 32'h0) && ((rsp_d & ~$past(qry_d)) == 32'h0));

    // R5
    ab_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> (rsp_a == $past(qry_a)) && (rsp_b == $past(qry_b)));

    // R5
    other_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && qry_func != FN_BASIC && qry_func != FN_EXT)
        |=> (rsp_c == $past(qry_c)) && (rsp_d == $past(qry_d)));

    // R8
    err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_wr || cfg_rd));

endmodule

bind featmask_unit featmask_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_err   (cfg_err),
    .qry_valid (qry_valid),
    .qry_func  (qry_func),
    .qry_a     (qry_a),
    .qry_b     (qry_b),
    .qry_c     (qry_c),
    .qry_d     (qry_d),
    .rsp_valid (rsp_valid),
    .rsp_a     (rsp_a),
    .rsp_b     (rsp_b),
    .rsp_c     (rsp_c),
    .rsp_d     (rsp_d)
);

// File: tb/featmask_unit_test.sv
module featmask_unit_test;

    localparam int NI = 3; // 0 dual, 1 single, 2 unsupported

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic        qry_valid = 1'b0;
    logic [31:0] qry_func = '0, qry_a = '0, qry_b = '0, qry_c = '0, qry_d = '0;

    logic [63:0] rdata [NI];
    logic        err   [NI];
    logic        rv    [NI];
    logic [31:0] ra [NI], rb [NI], rc [NI], rd [NI];

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    featmask_unit #(.PROC_SIG(32'h0002_06C2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(rdata[0]), .cfg_err(err[0]),
        .qry_valid(qry_valid), .qry_func(qry_func), .qry_a(qry_a), .qry_b(qry_b),
        .qry_c(qry_c), .qry_d(qry_d), .rsp_valid(rv[0]), .rsp_a(ra[0]),
        .rsp_b(rb[0]), .rsp_c(rc[0]), .rsp_d(rd[0]));

    featmask_unit #(.PROC_SIG(32'h0001_06D0)) uut_single (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(rdata[1]), .cfg_err(err[1]),
        .qry_valid(qry_valid), .qry_func(qry_func), .qry_a(qry_a), .qry_b(qry_b),
        .qry_c(qry_c), .qry_d(qry_d), .rsp_valid(rv[1]), .rsp_a(ra[1]),
        .rsp_b(rb[1]), .rsp_c(rc[1]), .rsp_d(rd[1]));

    featmask_unit #(.PROC_SIG(32'h0000_0F41)) uut_none (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(rdata[2]), .cfg_err(err[2]),
        .qry_valid(qry_valid), .qry_func(qry_func), .qry_a(qry_a), .qry_b(qry_b),
        .qry_c(qry_c), .qry_d(qry_d), .rsp_valid(rv[2]), .rsp_a(ra[2]),
        .rsp_b(rb[2]), .rsp_c(rc[2]), .rsp_d(rd[2]));

    typedef struct packed {
        logic [31:0] fn;
        logic [31:0] c;
        logic [31:0] d;
        logic [63:0] m_basic;
        logic [63:0] m_ext;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{32'h0000_0001, 32'h1234_5678, 32'h9ABC_DEF0, 64'h0F0F_0F0F_F0F0_F0F0, 64'h0000_0000_0000_0000},
        '{32'h8000_0001, 32'hFFFF_FFFF, 32'hAAAA_5555, 64'h0000_0000_0000_0000, 64'h00FF_00FF_FFFF_0000},
        '{32'h0000_0001, 32'h0080_0000, 32'h0000_0000, 64'hFFFF_FFFF_FF7F_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{32'h0000_0007, 32'hDEAD_BEEF, 32'hCAFE_F00D, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{32'h8000_0001, 32'h5A5A_A5A5, 32'h0F0F_F0F0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] addr, input logic [63:0] data);
        @(negedge clk);
        cfg_addr = addr; cfg_wdata = data; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [31:0] addr);
        @(negedge clk);
        cfg_addr = addr; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic query(input logic [31:0] fn, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d);
        @(negedge clk);
        qry_valid = 1'b1; qry_func = fn; qry_a = a; qry_b = b; qry_c = c; qry_d = d;
        @(negedge clk);
        qry_valid = 1'b0;
    endtask

    task automatic expect_rsp(input int k, input string req, input logic [31:0] ea,
                              input logic [31:0] eb, input logic [31:0] ec, input logic [31:0] ed);
        check(rv[k] == 1'b1, req, {63'h0, rv[k]}, 64'h1);
        check({ra[k], rb[k]} == {ea, eb}, req, {ra[k], rb[k]}, {ea, eb});
        check({rc[k], rd[k]} == {ec, ed}, req, {rc[k], rd[k]}, {ec, ed});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        logic [31:0] ec, ed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(rv[0] == 1'b0 && err[0] == 1'b0, "R1", {62'h0, rv[0], err[0]}, 64'h0);
        cfg_read(32'h130);
        check(rdata[0] == '1 && !err[0], "R1", rdata[0], '1);
        cfg_read(32'h131);
        check(rdata[0] == '1 && !err[0], "R1", rdata[0], '1);
        cfg_read(32'h478);
        check(rdata[1] == '1 && !err[1], "R1", rdata[1], '1);
        query(32'h1, 32'h11, 32'h22, 32'h3333_CCCC, 32'h4444_BBBB);
        expect_rsp(0, "R1", 32'h11, 32'h22, 32'h3333_CCCC, 32'h4444_BBBB);
        @(negedge clk);
        check(rv[0] == 1'b0, "R10", {63'h0, rv[0]}, 64'h0);

        // R2 R3 R5 R11 vector table on the dual-mask build
        foreach (VECS[i]) begin
            cfg_write(32'h130, VECS[i].m_basic);
            cfg_write(32'h131, VECS[i].m_ext);
            query(VECS[i].fn, 32'hA0A0_0000 + i, 32'hB0B0_0000 + i, VECS[i].c, VECS[i].d);
            ec = VECS[i].c; ed = VECS[i].d;
            if (VECS[i].fn == 32'h1) begin
                ec = ec & VECS[i].m_basic[31:0]; ed = ed & VECS[i].m_basic[63:32];
            end else if (VECS[i].fn == 32'h8000_0001) begin
                ec = ec & VECS[i].m_ext[31:0];   ed = ed & VECS[i].m_ext[63:32];
            end
            expect_rsp(0, "R2 R3 R5 R11 table", 32'hA0A0_0000 + i, 32'hB0B0_0000 + i, ec, ed);
            // R7 unsupported build stays untouched
            expect_rsp(2, "R7 table", 32'hA0A0_0000 + i, 32'hB0B0_0000 + i, VECS[i].c, VECS[i].d);
            // R11 bit 23 specifically
            if (i == 3) check(rc[0][23] == 1'b0, "R11", {32'h0, rc[0]}, 64'h0);
        end

        // R9 full-width read back
        cfg_write(32'h130, 64'h1357_9BDF_2468_ACE0);
        cfg_read(32'h130);
        check(rdata[0] == 64'h1357_9BDF_2468_ACE0 && !err[0], "R9", rdata[0], 64'h1357_9BDF_2468_ACE0);

        // R8 unimplemented write: error pulse, no state change
        cfg_write(32'h132, 64'h0);
        check(err[0] == 1'b1, "R8", {63'h0, err[0]}, 64'h1);
        @(negedge clk);
        check(err[0] == 1'b0, "R8 pulse", {63'h0, err[0]}, 64'h0);
        cfg_read(32'h130);
        check(rdata[0] == 64'h1357_9BDF_2468_ACE0, "R8", rdata[0], 64'h1357_9BDF_2468_ACE0);
        cfg_read(32'h131);
        check(rdata[0] == 64'hFFFF_FFFF_FFFF_FFFF, "R8", rdata[0], '1);

        // R4 single-mask build layout
        cfg_write(32'h130, '1);
        cfg_write(32'h131, '1);
        cfg_write(32'h478, 64'h0000_FFFF_FFFF_0000);
        check(err[1] == 1'b0 && err[0] == 1'b1, "R4 478", {62'h0, err[1], err[0]}, 64'h1);
        cfg_read(32'h478);
        check(rdata[1] == 64'h0000_FFFF_FFFF_0000, "R4 R9", rdata[1], 64'h0000_FFFF_FFFF_0000);
        cfg_read(32'h131);
        check(err[1] == 1'b1, "R4 R8 131", {63'h0, err[1]}, 64'h1);
        cfg_write(32'h130, 64'h0);
        check(err[1] == 1'b1, "R4 R8 130", {63'h0, err[1]}, 64'h1);
        query(32'h1, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        expect_rsp(1, "R4 basic", 32'h1, 32'h2, 32'hFFFF_0000, 32'h0000_FFFF);
        expect_rsp(0, "R2 zero mask", 32'h1, 32'h2, 32'h0, 32'h0);
        expect_rsp(2, "R7", 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        cfg_write(32'h131, 64'h0);
        query(32'h8000_0001, 32'h3, 32'h4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        expect_rsp(1, "R4 ext passes", 32'h3, 32'h4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        expect_rsp(0, "R3 zero mask", 32'h3, 32'h4, 32'h0, 32'h0);

        // R7 unsupported build errors on every address
        cfg_read(32'h478);
        check(err[2] == 1'b1, "R7", {63'h0, err[2]}, 64'h1);
        cfg_read(32'h130);
        check(err[2] == 1'b1, "R7", {63'h0, err[2]}, 64'h1);

        // R10 write and query in the same cycle: old mask, then new mask
        cfg_write(32'h130, '1);
        @(negedge clk);
        cfg_addr = 32'h130; cfg_wdata = 64'h0; cfg_wr = 1'b1;
        qry_valid = 1'b1; qry_func = 32'h1; qry_a = 32'h5; qry_b = 32'h6;
        qry_c = 32'hFFFF_FFFF; qry_d = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_wr = 1'b0;
        expect_rsp(0, "R10 old mask", 32'h5, 32'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        @(negedge clk);
        qry_valid = 1'b0;
        expect_rsp(0, "R10 new mask", 32'h5, 32'h6, 32'h0, 32'h0);
        @(negedge clk);
        check(rv[0] == 1'b0, "R10", {63'h0, rv[0]}, 64'h0);

        finish_run();
    end

endmodule